// File: doc/BRIEF.md
# Power-Fail Memory Write-Protect Controller

This controller sits between a host memory bus and a byte-wide static RAM. Its job is to keep the RAM contents intact while the supply is collapsing or recovering. Two comparator flags come from the analog side. One says the supply is below the deselect threshold. The other says it is below the level at which a backup cell should take over. Both flags pass through a synchroniser first. The host's active-low chip, write and output strobes then drive registered copies to the RAM whenever the supply is good.

When the supply fails, the controller blocks the RAM. An access that is already running may finish, but only inside a grace window of `WP_CYCLES` clocks. If the access is still running at the end of that window, the controller cuts it off. Once the supply is good again, protection stays in place for `ER_CYCLES` clocks so the host can settle. A new dip during that period starts the wait over. Reset also leaves the block protected for one full recovery period. A separate output selects the backup source while the lower flag is set.

The state machine has four states:
- `ST_RUN`: normal pass-through.
- `ST_GRACE`: an old access finishes while the supply is low.
- `ST_LOCK`: protected, waiting for the supply.
- `ST_RECOVER`: protected, counting out the recovery time.

It has these transitions:
- RUN→GRACE when the low flag is seen with chip enable low.
- RUN→LOCK when the low flag is seen with chip enable high.
- GRACE→LOCK when chip enable rises or the window runs out.
- LOCK→RECOVER when the low flag clears.
- RECOVER→LOCK when the low flag returns.
- RECOVER→RUN when the recovery count completes.

Top module: `pfail_guard`

## Requirements
- R1: While reset is asserted, all three RAM strobes are high, `prot_flag` is 1 and `batt_sel` is 0. After release with the low flag clear, `prot_flag` stays 1 for exactly `ER_CYCLES` clock edges.
- R2: Each raw flag passes through two synchroniser flops. A change on `lowv_raw` does not alter any output until the third clock edge after it is driven.
- R3: In `ST_RUN`, each RAM strobe equals the host strobe from before the previous clock edge (one register of latency). A write window on the RAM therefore opens at the later falling edge of chip and write enable and closes at the earlier rising edge.
- R4: If the low flag is seen with host chip enable high, `prot_flag` is 1 and all RAM strobes are high from the third edge after `lowv_raw` rises.
- R5: If the low flag is seen with host chip enable low, the strobes keep passing through (`ST_GRACE`) for as long as chip enable stays low, up to the grace window.
- R6: If chip enable is still low after `WP_CYCLES` edges in `ST_GRACE`, the RAM strobes are forced high and `prot_flag` goes to 1.
- R7: Whenever `prot_flag` is 1, all three RAM strobes are high whatever the host drives. A high output enable keeps the RAM data pins in high impedance.
- R8: After `lowv_raw` falls, `prot_flag` returns to 0 exactly `ER_CYCLES + 3` edges later.
- R9: A reassertion of the synchronised low flag during `ST_RECOVER` returns the block to `ST_LOCK`. The full recovery count restarts once the flag clears again.
- R10: `batt_sel` follows `swov_raw` through the two synchroniser flops plus one output register, changing on the third edge.
- R11: A chip-enable rise in `ST_GRACE` moves the block to `ST_LOCK`. A following chip-enable fall does not reach the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowv_raw | input | 1 | Supply below deselect threshold (unsynchronised) |
| swov_raw | input | 1 | Supply below backup switchover threshold (unsynchronised) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to RAM |
| mem_we_n | output | 1 | Gated write enable to RAM |
| mem_oe_n | output | 1 | Gated output enable to RAM |
| batt_sel | output | 1 | 1 selects the backup source |
| prot_flag | output | 1 | 1 while the RAM is protected |

## Verification
The assertions assume the host strobes are synchronous to `clk` and held stable across each edge. They also assume the supply flags stay put long enough for the synchroniser to see them. Pulses shorter than a clock period are not modelled. The stimulus drives every input only at the falling clock edge. Random flag toggles are kept rare, so each power episode runs through grace, lock and recovery before the next one. Directed cases hold chip enable low across the flag to reach the grace expiry, and pulse the flag inside recovery to reach the restart.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_GRACE   = 2'd1,
        ST_LOCK    = 2'd2,
        ST_RECOVER = 2'd3
    } pfg_state_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
    parameter int          CNT_W   = 5,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= CNT_W'(RST_VAL);
        else if (load)                   cnt_q <= load_val;
        else if (dec && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
#(
    parameter int WP_CYCLES = 8,
    parameter int ER_CYCLES = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_s,
    input  logic             host_ce_n,
    input  logic             tmr_zero,
    output pfg_state_e       state_q,
    output pfg_state_e       state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_dec
);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYCLES - 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ER_CYCLES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RECOVER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (low_s) begin
                    if (!host_ce_n) begin
                        state_d  = ST_GRACE;
                        tmr_load = 1'b1;
                        tmr_val  = WP_LOAD;
                    end else begin
                        state_d  = ST_LOCK;
                    end
                end
            end
            ST_GRACE: begin
                if (host_ce_n || tmr_zero) state_d = ST_LOCK;
                else                       tmr_dec = 1'b1;
            end
            ST_LOCK: begin
                if (!low_s) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = ER_LOAD;
                end
            end
            ST_RECOVER: begin
                if (low_s)         state_d = ST_LOCK;
                else if (tmr_zero) state_d = ST_RUN;
                else               tmr_dec = 1'b1;
            end
            default: state_d = ST_LOCK;
        endcase
    end
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
    import pfg_pkg::*;
#(
    parameter int WP_CYCLES   = 8,
    parameter int ER_CYCLES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lowv_raw,
    input  logic swov_raw,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic host_oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic batt_sel,
    output logic prot_flag
);
    localparam int MAX_CYC = (WP_CYCLES > ER_CYCLES) ? WP_CYCLES : ER_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [1:0]       flags_s;
    logic             low_s;
    logic             sw_s;
    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    pfg_state_e       state_q;
    pfg_state_e       state_d;
    logic             pass_d;
    logic             prot_d;

    pfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({swov_raw, lowv_raw}),
        .q     (flags_s)
    );

    assign low_s = flags_s[0];
    assign sw_s  = flags_s[1];

    pfg_timer #(.CNT_W(CNT_W), .RST_VAL(ER_CYCLES - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pfg_fsm #(.WP_CYCLES(WP_CYCLES), .ER_CYCLES(ER_CYCLES), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_s     (low_s),
        .host_ce_n (host_ce_n),
        .tmr_zero  (tmr_zero),
        .state_q   (state_q),
        .state_d   (state_d),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_dec   (tmr_dec)
    );

    // Output decode from the next state, so outputs register with the state.
    always_comb begin
        pass_d = (state_d == ST_RUN) || (state_d == ST_GRACE);
        prot_d = (state_d == ST_LOCK) || (state_d == ST_RECOVER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            prot_flag <= 1'b1;
            batt_sel  <= 1'b0;
        end else begin
            mem_ce_n  <= pass_d ? host_ce_n : 1'b1;
            mem_we_n  <= pass_d ? host_we_n : 1'b1;
            mem_oe_n  <= pass_d ? host_oe_n : 1'b1;
            prot_flag <= prot_d;
            batt_sel  <= sw_s;
        end
    end
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
    import pfg_pkg::*;
#(
    parameter int WP_CYCLES = 8,
    parameter int ER_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input pfg_state_e state_q,
    input logic       low_s,
    input logic       host_ce_n,
    input logic       host_we_n,
    input logic       host_oe_n,
    input logic       mem_ce_n,
    input logic       mem_we_n,
    input logic       mem_oe_n,
    input logic       prot_flag
);
    int unsigned gc_q;
    int unsigned rc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gc_q <= 0;
            rc_q <= 0;
        end else begin
            gc_q <= (state_q == ST_GRACE)   ? gc_q + 1 : 0;
            rc_q <= (state_q == ST_RECOVER) ? rc_q + 1 : 0;
        end
    end

    p_prot_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_flag |-> (mem_ce_n && mem_we_n && mem_oe_n));

    p_run_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (mem_ce_n == $past(host_ce_n) &&
                                 mem_we_n == $past(host_we_n) &&
                                 mem_oe_n == $past(host_oe_n)));

    p_grace_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE) |-> (!mem_ce_n && mem_we_n == $past(host_we_n)));

    p_grace_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gc_q <= WP_CYCLES);

    p_grace_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRACE && host_ce_n) |=> (state_q == ST_LOCK));

    p_low_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && low_s && host_ce_n) |=> prot_flag);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && low_s) |=> (state_q == ST_LOCK));

    p_recover_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rc_q != 0) |-> (rc_q == ER_CYCLES));
endmodule

bind pfail_guard pfg_checker #(.WP_CYCLES(WP_CYCLES), .ER_CYCLES(ER_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .low_s     (low_s),
    .host_ce_n (host_ce_n),
    .host_we_n (host_we_n),
    .host_oe_n (host_oe_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .prot_flag (prot_flag)
);

// File: tb/tb_pfail_guard.sv
module tb_pfail_guard;
    localparam int WP = 5;
    localparam int ER = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lowv_raw = 1'b0, swov_raw = 1'b0;
    logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic mem_ce_n, mem_we_n, mem_oe_n, batt_sel, prot_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;
    string cur_tag = "";

    // bench model of the requirements
    int m_mode = 3;            // 0 run, 1 grace, 2 lock, 3 recover
    int m_cnt  = ER - 1;
    bit s1 = 0, s2 = 0, w1 = 0, w2 = 0;
    bit e_ce = 1, e_we = 1, e_oe = 1, e_prot = 1, e_batt = 0;

    always #5 clk = ~clk;

    pfail_guard #(.WP_CYCLES(WP), .ER_CYCLES(ER)) dut (
        .clk(clk), .rst_n(rst_n), .lowv_raw(lowv_raw), .swov_raw(swov_raw),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .batt_sel(batt_sel), .prot_flag(prot_flag)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int nm;
        bit pass;
        if (!rst_n) begin
            m_mode = 3; m_cnt = ER - 1;
            s1 = 0; s2 = 0; w1 = 0; w2 = 0;
            e_ce = 1; e_we = 1; e_oe = 1; e_prot = 1; e_batt = 0;
            return;
        end
        nm = m_mode;
        case (m_mode)
            0: if (s2) begin
                   if (!host_ce_n) begin nm = 1; m_cnt = WP - 1; end
                   else nm = 2;
               end
            1: if (host_ce_n || m_cnt == 0) nm = 2; else m_cnt--;
            2: if (!s2) begin nm = 3; m_cnt = ER - 1; end
            default: if (s2) nm = 2; else if (m_cnt == 0) nm = 0; else m_cnt--;
        endcase
        m_mode = nm;
        pass   = (nm == 0) || (nm == 1);
        e_ce   = pass ? host_ce_n : 1'b1;
        e_we   = pass ? host_we_n : 1'b1;
        e_oe   = pass ? host_oe_n : 1'b1;
        e_prot = (nm >= 2);
        e_batt = w2;
        s2 = s1; s1 = lowv_raw;
        w2 = w1; w1 = swov_raw;
    endtask

    task automatic tick();
        string t;
        @(posedge clk);
        model_edge();
        #1;
        t = (cur_tag != "") ? cur_tag : (e_prot ? "R7" : "R3");
        chk(mem_ce_n == e_ce, t, "mem_ce_n", mem_ce_n, e_ce);
        chk(mem_we_n == e_we, t, "mem_we_n", mem_we_n, e_we);
        chk(mem_oe_n == e_oe, t, "mem_oe_n", mem_oe_n, e_oe);
        chk(prot_flag == e_prot, t, "prot_flag", prot_flag, e_prot);
        chk(batt_sel == e_batt, "R10", "batt_sel", batt_sel, e_batt);
        @(negedge clk);
    endtask

    task automatic ticks_until_unprot(output int n);
        n = 0;
        do begin tick(); n++; end while (prot_flag && n < 200);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int n;
        void'($urandom(32'd2024));
        // R1: reset state
        cur_tag = "R1";
        repeat (3) tick();
        chk(prot_flag == 1 && mem_ce_n && mem_we_n && mem_oe_n && !batt_sel,
            "R1", "reset outputs", prot_flag, 1);
        rst_n = 1'b1;
        ticks_until_unprot(n);
        chk(n == ER, "R1", "protect cycles after reset", n, ER);

        // R3: write window passes through with one cycle latency
        cur_tag = "R3";
        host_ce_n = 0; tick();
        chk(mem_ce_n == 0 && mem_we_n == 1, "R3", "ce only", mem_ce_n, 0);
        host_we_n = 0; tick();
        chk(mem_we_n == 0, "R3", "write open", mem_we_n, 0);
        host_we_n = 1; tick();
        chk(mem_we_n == 1, "R3", "write closed", mem_we_n, 1);
        host_ce_n = 1; tick();

        // R2 / R4 / R7 / R8: failure with no access
        cur_tag = "R4";
        lowv_raw = 1; tick(); tick();
        chk(prot_flag == 0, "R2", "prot after two edges", prot_flag, 0);
        tick();
        chk(prot_flag == 1, "R4", "prot after three edges", prot_flag, 1);
        cur_tag = "R7";
        host_ce_n = 0; host_we_n = 0; host_oe_n = 0; tick(); tick();
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R7", "strobes blocked", mem_we_n, 1);
        host_ce_n = 1; host_we_n = 1; host_oe_n = 1;
        cur_tag = "R8";
        lowv_raw = 0;
        ticks_until_unprot(n);
        chk(n == ER + 3, "R8", "recovery length", n, ER + 3);

        // R5 / R11: access finishes in grace, then no new access
        cur_tag = "R5";
        host_ce_n = 0; host_we_n = 0; tick();
        lowv_raw = 1; repeat (4) tick();
        chk(mem_we_n == 0 && prot_flag == 0, "R5", "grace write passes", mem_we_n, 0);
        cur_tag = "R11";
        host_ce_n = 1; host_we_n = 1; tick();
        chk(prot_flag == 1, "R11", "lock after ce rise", prot_flag, 1);
        host_ce_n = 0; tick();
        chk(mem_ce_n == 1, "R11", "new access blocked", mem_ce_n, 1);
        host_ce_n = 1;
        lowv_raw = 0; ticks_until_unprot(n);

        // R6: grace window expires
        cur_tag = "R6";
        host_ce_n = 0; tick();
        lowv_raw = 1; repeat (3) tick();
        n = 0;
        while (mem_ce_n == 0 && n < 100) begin tick(); n++; end
        chk(n == WP, "R6", "grace length", n, WP);
        host_ce_n = 1;
        lowv_raw = 0; repeat (5) tick();

        // R9: dip during recovery restarts the count
        cur_tag = "R9";
        lowv_raw = 1; tick();
        lowv_raw = 0;
        ticks_until_unprot(n);
        chk(n == ER + 3, "R9", "restarted recovery", n, ER + 3);

        // R10: backup select
        cur_tag = "R10";
        swov_raw = 1; tick(); tick();
        chk(batt_sel == 0, "R10", "batt after two edges", batt_sel, 0);
        tick();
        chk(batt_sel == 1, "R10", "batt after three edges", batt_sel, 1);
        swov_raw = 0; repeat (4) tick();

        // random mix
        cur_tag = "";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 2)      lowv_raw = ~lowv_raw;
            else if (r < 4) swov_raw = ~swov_raw;
            if (!host_ce_n) begin
                if (($urandom % 100) < 20) host_ce_n = 1;
            end else if (($urandom % 100) < 30) host_ce_n = 0;
            host_we_n = ($urandom % 2) != 0;
            host_oe_n = ($urandom % 2) != 0;
            tick();
        end
        summary();
    end
endmodule